// File: doc/BRIEF.md
# Multi-Slot Averaging Conversion Sequencer

This block drives an external sample converter on behalf of four independently configured conversion slots, numbered 0 to 3. Each slot names one of sixteen physical inputs and may ask for a power-of-two number of samples to be averaged. An enabled slot asks the sequencer for service. The sequencer serves one slot at a time: it requests samples from the converter, sums them, and divides the sum by shifting it. It then stores the 12-bit result in a packed result word and pulses that slot's done line.

A slot in one-shot mode drops its own enable once its result is stored. A slot in free-running mode stays enabled and is served again. Configuration goes in through a simple register write port, and a registered read port returns the configuration and the result words. The analog converter is modelled outside the block. The block sees it as a request and select pair that is answered by a valid pulse carrying a 12-bit sample.

Top module: `avg_conv_ctrl`

## Requirements
- R1: Each slot has a control word at byte address slot*0x20. Bit 31 enables the slot, bit 30 selects one-shot mode, bit 29 turns averaging on, and bits 27:24 pick the physical input. The read port returns these fields, and every other bit of the word reads as zero.
- R2: Each slot has a count word at slot*0x20+0x10. Bits 13:12 hold the count code: 0 means 4 samples, 1 means 8, 2 means 16 and 3 means 32. The read port returns only this field.
- R3: With averaging on, the result is the floor of the sum of the 2^(code+2) samples divided by their count. Thirty-two samples of 4095 give 4095, with no wraparound.
- R4: With averaging off, exactly one sample is taken and it becomes the result unchanged.
- R5: While a slot is served, cnv_req is high and cnv_sel equals the slot's input. Both hold steady until a cnv_valid arrives, and cnv_req falls right after the last sample of the run.
- R6: Slots waiting together are served in fixed order 0, 1, 2, 3. A run finishes all of its samples before the next slot is started.
- R7: Result word 0 (read address 0x80, bits 31:0 of res_words) holds slot 0 in bits 11:0 and slot 1 in bits 27:16. Result word 1 (0x90, bits 63:32) holds slots 2 and 3 in the same way. The remaining bits are zero, and a field changes only when its slot completes.
- R8: done[k] is high for exactly one cycle, in the first cycle in which slot k's new result is visible on res_words. At most one done bit is ever high.
- R9: A one-shot slot reads back with its enable bit cleared after it completes. A free-running slot stays enabled and keeps producing results until software clears its enable.
- R10: After reset, all configuration and result words are zero, cnv_req is low and done is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, valid one cycle after rd_addr |
| cnv_req | output | 1 | Sample request to converter |
| cnv_sel | output | 4 | Physical input for the requested sample |
| cnv_valid | input | 1 | Converter returns a sample this cycle |
| cnv_data | input | 12 | Returned sample |
| done | output | 4 | One-cycle completion pulse per slot |
| res_words | output | 64 | Packed result words, two slots each |

## Verification
The bench sums the samples it hands to the converter for each run and compares the quotient with the packed field on every done pulse. A count decoded off by one shows up as a wrong sample count and a wrong quotient. Thirty-two full-scale samples expose an accumulator that is too narrow, because the result wraps well below 4095. Three slots are enabled while a long 32-sample run is in progress, so a priority error or an interrupted run shows up as a scoreboard order mismatch or a mixed-input sample log. Control-word readback after a one-shot run catches a sticky enable, and a free-running slot that stops after one result is caught by its missing second pulse.

// File: rtl/avgc_pkg.sv
package avgc_pkg;
  localparam int SMP_W   = 12;
  localparam int SEL_W   = 4;
  localparam int CODE_W  = 2;
  localparam int MIN_LOG = 2;
  localparam int MAX_LOG = MIN_LOG + (1 << CODE_W) - 1;
  localparam int ACC_W   = SMP_W + MAX_LOG;
  localparam int CNT_W   = MAX_LOG + 1;
  localparam int SHF_W   = $clog2(MAX_LOG + 1);

  localparam int B_EN   = 31;
  localparam int B_ONE  = 30;
  localparam int B_AVG  = 29;
  localparam int B_SEL  = 24;
  localparam int B_CODE = 12;
  localparam int B_ODD  = 16;

  typedef struct packed {
    logic              en;
    logic              one_shot;
    logic              avg_on;
    logic [SEL_W-1:0]  sel;
    logic [CODE_W-1:0] code;
  } slot_cfg_t;

  function automatic logic [SHF_W-1:0] shift_of(slot_cfg_t c);
    return c.avg_on ? SHF_W'(MIN_LOG + int'(c.code)) : '0;
  endfunction
endpackage

// File: rtl/avgc_slot_regs.sv
module avgc_slot_regs
  import avgc_pkg::*;
#(
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic                    wr_cnt,
  input  logic [31:0]             wr_data,
  input  logic [SLOTS-1:0]        clr_en,
  output slot_cfg_t [SLOTS-1:0]   cfg_q
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[k] <= '0;
      end else begin
        if (clr_en[k]) cfg_q[k].en <= 1'b0;
        if (wr_en && wr_slot == SLOT_W'(k)) begin
          if (!wr_cnt) begin
            cfg_q[k].en       <= wr_data[B_EN];
            cfg_q[k].one_shot <= wr_data[B_ONE];
            cfg_q[k].avg_on   <= wr_data[B_AVG];
            cfg_q[k].sel      <= wr_data[B_SEL +: SEL_W];
          end else begin
            cfg_q[k].code     <= wr_data[B_CODE +: CODE_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/avgc_pick.sv
module avgc_pick #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
)(
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/avgc_accum.sv
module avgc_accum
  import avgc_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int AW = ACC_W,
  parameter int CW = CNT_W
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          take,
  input  logic [SW-1:0] sample,
  output logic [AW-1:0] acc,
  output logic [CW-1:0] cnt
);
  localparam int MAX_N = 1 << (AW - SW);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= '0;
      cnt <= '0;
    end else if (take) begin
      acc <= acc + AW'(sample);
      cnt <= cnt + 1'b1;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) <= MAX_N) && (int'(acc) <= int'(cnt) * ((1 << SW) - 1)));
endmodule

// File: rtl/avg_conv_ctrl.sv
module avg_conv_ctrl
  import avgc_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int NPAIR  = SLOTS / 2,
  localparam int PAIR_W = (NPAIR > 1) ? $clog2(NPAIR) : 1,
  localparam int PITCH  = 32,
  localparam int RES_BASE = SLOTS * PITCH
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [31:0]            wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [31:0]            rd_data,
  output logic                   cnv_req,
  output logic [SEL_W-1:0]       cnv_sel,
  input  logic                   cnv_valid,
  input  logic [SMP_W-1:0]       cnv_data,
  output logic [SLOTS-1:0]       done,
  output logic [NPAIR*32-1:0]    res_words
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  slot_cfg_t [SLOTS-1:0] cfg_q;
  slot_cfg_t             snap;
  logic [SLOT_W-1:0]     cur;
  logic [SLOTS-1:0]      clr_en;
  logic [SLOTS-1:0]      pend;
  logic                  any;
  logic [SLOT_W-1:0]     pick;
  logic [ACC_W-1:0]      acc;
  logic [CNT_W-1:0]      cnt;
  logic [SMP_W-1:0]      res_lo [NPAIR];
  logic [SMP_W-1:0]      res_hi [NPAIR];

  // register write decode
  logic wr_cfg;
  assign wr_cfg = wr_en && (int'(wr_addr) < RES_BASE) && (wr_addr[3:0] == 4'h0);

  for (genvar k = 0; k < SLOTS; k++) begin : g_pend
    assign pend[k]   = cfg_q[k].en;
    assign clr_en[k] = (st == S_FIN) && (cur == SLOT_W'(k)) && snap.one_shot;
  end

  avgc_slot_regs #(.SLOTS(SLOTS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_cfg),
    .wr_slot(wr_addr[5 +: SLOT_W]), .wr_cnt(wr_addr[4]),
    .wr_data(wr_data), .clr_en(clr_en), .cfg_q(cfg_q)
  );

  avgc_pick #(.N(SLOTS)) u_pick (.req(pend), .any(any), .idx(pick));

  logic start, take, last;
  assign start = (st == S_IDLE) && any;
  assign take  = (st == S_RUN) && cnv_valid;
  assign last  = (cnt == CNT_W'((1 << shift_of(snap)) - 1));

  avgc_accum u_acc (
    .clk(clk), .rst(rst), .clear(start), .take(take),
    .sample(cnv_data), .acc(acc), .cnt(cnt)
  );

  logic [SMP_W-1:0] avg_val;
  assign avg_val = SMP_W'(acc >> shift_of(snap));

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cur     <= '0;
      snap    <= '0;
      cnv_req <= 1'b0;
      cnv_sel <= '0;
      done    <= '0;
    end else begin
      done <= '0;
      case (st)
        S_IDLE: if (any) begin
          cur     <= pick;
          snap    <= cfg_q[pick];
          cnv_sel <= cfg_q[pick].sel;
          cnv_req <= 1'b1;
          st      <= S_RUN;
        end
        S_RUN: if (cnv_valid && last) begin
          cnv_req <= 1'b0;
          st      <= S_FIN;
        end
        S_FIN: begin
          done[cur] <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // packed result storage, one pair of fields per word
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) begin
        res_lo[p] <= '0;
        res_hi[p] <= '0;
      end else if (st == S_FIN && cur[SLOT_W-1:1] == (SLOT_W-1)'(p)) begin
        if (cur[0]) res_hi[p] <= avg_val;
        else        res_lo[p] <= avg_val;
      end
    end
    assign res_words[p*32 +: 32] =
      {{(B_ODD-SMP_W){1'b0}}, res_hi[p], {(B_ODD-SMP_W){1'b0}}, res_lo[p]};
  end

  // read port
  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (int'(rd_addr) < RES_BASE) begin
      if (rd_addr[3:0] == 4'h0) begin
        if (!rd_addr[4])
          rd_word = {cfg_q[rd_addr[5 +: SLOT_W]].en,
                     cfg_q[rd_addr[5 +: SLOT_W]].one_shot,
                     cfg_q[rd_addr[5 +: SLOT_W]].avg_on, 1'b0,
                     cfg_q[rd_addr[5 +: SLOT_W]].sel, 24'h0};
        else
          rd_word = {18'h0, cfg_q[rd_addr[5 +: SLOT_W]].code, 12'h0};
      end
    end else if (int'(rd_addr) < RES_BASE + NPAIR * 16 && rd_addr[3:0] == 4'h0) begin
      rd_word = res_words[int'(rd_addr[4 +: PAIR_W]) * 32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_word;
  end

  // R5 request held with a steady select until answered
  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    (cnv_req && !cnv_valid) |=> (cnv_req && $stable(cnv_sel)));

  // R8 never two completions at once
  a_r8_done_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));

  // R7 packed results move only together with a completion
  a_r7_res_quiet: assert property (@(posedge clk) disable iff (rst)
    (done == '0 && st != S_FIN) |=> (done != '0 || $stable(res_words)));

  // R9 one-shot slot drops its enable when it completes
  a_r9_oneshot_clear: assert property (@(posedge clk) disable iff (rst)
    (st == S_FIN && snap.one_shot && !wr_en) |=> !cfg_q[cur].en);
endmodule

// File: tb/tb_avg_conv_ctrl.sv
module tb_avg_conv_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cnv_req;
  logic [3:0]  cnv_sel;
  logic        cnv_valid = 1'b0;
  logic [11:0] cnv_data = '0;
  logic [3:0]  done;
  logic [63:0] res_words;

  always #4 clk = ~clk;

  avg_conv_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnv_req(cnv_req), .cnv_sel(cnv_sel),
    .cnv_valid(cnv_valid), .cnv_data(cnv_data), .done(done), .res_words(res_words)
  );

  typedef struct { int slot; int sel; int n; } item_t;
  item_t exp_q[$];
  item_t extra_it;
  bit    allow_extra = 0;

  int checks = 0, errors = 0, ndone = 0;
  int bsum = 0, bcnt = 0, run_sel = -1, gk = 0;
  bit maxmode = 0, sel_mix = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mk1(bit en, bit one, bit avg, int sel);
    return {en, one, avg, 1'b0, 4'(sel), 24'h0};
  endfunction

  function automatic int lg(int n);
    int r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_done(int target);
    while (ndone < target) @(negedge clk);
  endtask

  // converter model, logs what it hands out
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && cnv_req) begin
        repeat (2) @(posedge clk);
        #1;
        cnv_data = maxmode ? 12'hFFF : 12'((int'(cnv_sel) * 263 + gk * 97 + 5) % 4096);
        gk++;
        if (bcnt == 0) run_sel = int'(cnv_sel);
        else if (run_sel != int'(cnv_sel)) sel_mix = 1;
        bsum += int'(cnv_data);
        bcnt++;
        cnv_valid = 1'b1;
        @(posedge clk); #1;
        cnv_valid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done != 4'b0) begin
      int k;
      item_t it;
      logic [31:0] w;
      int f, expv;
      k = 0;
      for (int i = 0; i < 4; i++) if (done[i]) k = i;
      if (exp_q.size() > 0) it = exp_q.pop_front();
      else if (allow_extra) it = extra_it;
      else begin
        it.slot = -1; it.sel = -1; it.n = -1;
      end
      chk(k == it.slot, "R6 slot order", k, it.slot);
      chk(bcnt == it.n, "R3/R4 sample count", bcnt, it.n);
      chk(run_sel == it.sel && !sel_mix, "R5 input select", run_sel, it.sel);
      w = res_words[(k / 2) * 32 +: 32];
      f = (k % 2) ? int'(w[27:16]) : int'(w[11:0]);
      expv = (it.n > 0) ? (bsum >> lg(it.n)) : -1;
      chk(f == expv, "R3/R4/R8 result field", f, expv);
      chk((w & 32'hF000F000) == 0, "R7 unused bits", int'(w), 0);
      bsum = 0; bcnt = 0; sel_mix = 0;
      ndone++;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", ndone, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R10 reset state
    chk(cnv_req == 0, "R10 req", int'(cnv_req), 0);
    chk(done == 0, "R10 done", int'(done), 0);
    chk(res_words == 0, "R10 results", int'(res_words[31:0]), 0);
    rd(8'h00, d); chk(d == 0, "R10 cfg", int'(d), 0);

    // R1/R2 field readback on a disabled slot
    wr(8'h40, mk1(0, 1, 1, 10) | 32'h00F0FFFF);
    rd(8'h40, d); chk(d == 32'h6A000000, "R1 control readback", int'(d), 32'h6A000000);
    wr(8'h50, 32'hFFFFFFFF);
    rd(8'h50, d); chk(d == 32'h00003000, "R2 count readback", int'(d), 32'h3000);
    repeat (5) @(negedge clk);
    chk(cnv_req == 0, "R1 disabled slot idle", int'(cnv_req), 0);

    // slot 0, 4 samples
    base = ndone;
    exp_q.push_back('{0, 3, 4});
    wr(8'h10, 32'h0); wr(8'h00, mk1(1, 1, 1, 3));
    wait_done(base + 1);
    rd(8'h00, d); chk(d == 32'h63000000, "R9 one-shot enable cleared", int'(d), 32'h63000000);
    @(negedge clk);
    chk(done == 0, "R8 single-cycle done", int'(done), 0);

    // slot 2, 8 samples
    exp_q.push_back('{2, 10, 8});
    wr(8'h50, 32'h1000); wr(8'h40, mk1(1, 1, 1, 10));
    wait_done(base + 2);

    // slot 1, averaging off
    exp_q.push_back('{1, 7, 1});
    wr(8'h30, 32'h3000); wr(8'h20, mk1(1, 1, 0, 7));
    wait_done(base + 3);

    // slot 3, 32 full-scale samples
    maxmode = 1;
    exp_q.push_back('{3, 15, 32});
    wr(8'h70, 32'h3000); wr(8'h60, mk1(1, 1, 1, 15));
    wait_done(base + 4);
    maxmode = 0;
    chk(res_words[59:48] == 12'hFFF, "R3 full-scale average", int'(res_words[59:48]), 4095);
    chk(res_words[11:0] != 0 && res_words[43:32] != 0, "R7 pair fields retained",
        int'(res_words[11:0]), 1);

    // R6 priority: slots 3,2,1 enabled while slot 0 runs 32 samples
    exp_q.push_back('{0, 1, 32});
    exp_q.push_back('{1, 6, 16});
    exp_q.push_back('{2, 4, 4});
    exp_q.push_back('{3, 2, 1});
    wr(8'h10, 32'h3000); wr(8'h30, 32'h2000); wr(8'h50, 32'h0000);
    wr(8'h00, mk1(1, 1, 1, 1));
    wr(8'h60, mk1(1, 1, 0, 2));
    wr(8'h40, mk1(1, 1, 1, 4));
    wr(8'h20, mk1(1, 1, 1, 6));
    wait_done(base + 8);
    chk(exp_q.size() == 0, "R6 all served", exp_q.size(), 0);

    // R9 free-running slot 1
    extra_it = '{1, 9, 1};
    allow_extra = 1;
    exp_q.push_back(extra_it);
    exp_q.push_back(extra_it);
    wr(8'h20, mk1(1, 0, 0, 9));
    wait_done(base + 10);
    rd(8'h20, d); chk(d[31] == 1'b1, "R9 free-running stays enabled", int'(d[31]), 1);
    wr(8'h20, mk1(0, 0, 0, 9));
    repeat (20) @(negedge clk);
    allow_extra = 0;
    base = ndone;
    repeat (30) @(negedge clk);
    chk(ndone == base, "R9 stops after disable", ndone, base);
    chk(cnv_req == 0, "R9 no request after disable", int'(cnv_req), 0);

    rd(8'h80, d); chk(d == res_words[31:0], "R7 word 0 readback", int'(d), int'(res_words[31:0]));
    rd(8'h90, d); chk(d == res_words[63:32], "R7 word 1 readback", int'(d), int'(res_words[63:32]));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule